// File: doc/BRIEF.md
# Slot Power Limit Message Generator

This block sits in a downstream port. It decides when the port must tell the device on the far side of the link what power limit applies to its slot. When it sends, it builds the single data dword that carries that limit. Two events start a send. The first is a configuration write to the slot-capabilities register while the data link is up. The second is the data link coming up, provided the slot register has been initialized. The request is held, with a frozen payload, until the transmit path accepts it with a one-cycle pulse. If a new event arrives while a request is waiting, the block remembers it and sends exactly one more message, built from the register contents at the moment that follow-up request starts.

A receive-side part models the upstream port on the far side. On each incoming payload it copies the limit value and scale into a local device-capabilities copy. A build-time option instead ties both fields to zero and ignores the payload. Header formation, CRC and the rest of configuration space belong to other blocks.

Top module: `spl_msg_gen`

## Requirements
- R1: After synchronous active-low reset, `msg_req` is 0 and both `dev_limit_value` and `dev_limit_scale` read 0.
- R2: While `msg_req` is high, `msg_payload` bits 7:0 equal the limit value, bits 9:8 equal the limit scale, and bits 31:10 are zero.
- R3: A cycle with `slot_cfg_wr` high and `dl_up` high, with no request outstanding, raises `msg_req` on the next cycle. The payload is built from the fields present in that cycle.
- R4: While `dl_up` is low, no trigger is taken: a `slot_cfg_wr` pulse leaves `msg_req` low.
- R5: The first cycle in which `dl_up` is high after having been low raises `msg_req` on the next cycle when `slot_init` is 1. Keeping `dl_up` high starts no further send.
- R6: A rising edge of `dl_up` while `slot_init` is 0 starts no send.
- R7: While `msg_req` is high and `msg_accept` is low, `msg_req` stays high and `msg_payload` stays unchanged. After an accept with nothing pending, `msg_req` is low on the next cycle.
- R8: Any number of triggers taken while a request waits collapse into exactly one further request. That request is raised in the cycle after the accept and is built from the fields present in the accept cycle.
- R9: With the hardwire option off, a cycle with `rx_msg_valid` high loads `dev_limit_value` from received bits 7:0 and `dev_limit_scale` from bits 9:8. Bits 31:10 are ignored, and the copies hold while `rx_msg_valid` is low.
- R10: With the hardwire option on (`RX_HARDWIRE`=1), `dev_limit_value` and `dev_limit_scale` stay 0 whatever payload arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_value | input | 8 | Slot power limit value field |
| slot_scale | input | 2 | Slot power limit scale field |
| slot_cfg_wr | input | 1 | Configuration write strobe to the slot-capabilities register |
| slot_init | input | 1 | Slot register has been initialized |
| dl_up | input | 1 | Data link up status |
| msg_req | output | 1 | Message send request to the transmit path |
| msg_payload | output | 32 | Data dword of the message |
| msg_accept | input | 1 | One-cycle accept from the transmit path |
| rx_msg_valid | input | 1 | Incoming limit message present (receive side) |
| rx_msg_payload | input | 32 | Incoming data dword |
| dev_limit_value | output | 8 | Device-capabilities copy of the limit value |
| dev_limit_scale | output | 2 | Device-capabilities copy of the limit scale |

## Verification
The bench aims at the cases where the two triggers are easy to mix up. One case is a write while the link is down, which a careless gate would send anyway. Another is a link-up edge with the register uninitialized. A third is a link held up, which a level-sensitive detector would resend every cycle. Back-to-back writes during an unaccepted request must yield exactly one extra message carrying the newest fields. A design that dropped the pending flag would lose the update, and one that counted triggers would send too many. The receive side is fed a payload with its reserved bits set, which exposes a copy taken from the wrong byte or wrong width, and the hardwired variant must show zero for that same payload.

// File: rtl/spl_pkg.sv
// Shared widths and payload packing for the slot power limit message logic.
// Assumes the fixed one-dword layout: value in bits 7:0, scale in bits 9:8.
package spl_pkg;
    localparam int LIMIT_VAL_W = 8;
    localparam int LIMIT_SCL_W = 2;
    localparam int MSG_DW      = 32;
    localparam int SCALE_LSB   = 8;
    localparam int USED_W      = SCALE_LSB + LIMIT_SCL_W;

    // Build the data dword; every bit outside the two fields is zero.
    function automatic logic [MSG_DW-1:0] pack_limit(
        input logic [LIMIT_VAL_W-1:0] value,
        input logic [LIMIT_SCL_W-1:0] scale
    );
        logic [MSG_DW-1:0] word;
        word = '0;
        word[LIMIT_VAL_W-1:0] = value;
        word[SCALE_LSB +: LIMIT_SCL_W] = scale;
        return word;
    endfunction
endpackage

// File: rtl/spl_trigger.sv
// Decides when a send is due: a register write while the link is up, or a
// rising edge of link-up while the slot register is initialized.
// Assumes dl_up is already synchronous to clk.
module spl_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic dl_up,
    input  logic slot_init,
    output logic fire
);
    logic dl_up_q;
    logic link_rise;

    // Registered copy of link status for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) dl_up_q <= 1'b0;
        else        dl_up_q <= dl_up;
    end

    // Combine the two trigger sources.
    always_comb begin
        link_rise = dl_up && !dl_up_q;
        fire      = (cfg_wr && dl_up) || (link_rise && slot_init);
    end
endmodule

// File: rtl/spl_tx_ctrl.sv
// Holds the send request and its payload until accepted, and folds any
// triggers seen while waiting into one pending follow-up send.
// Assumes msg_accept is only asserted while the request is high.
module spl_tx_ctrl
    import spl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fire,
    input  logic [LIMIT_VAL_W-1:0] value,
    input  logic [LIMIT_SCL_W-1:0] scale,
    input  logic                   accept,
    output logic                   req,
    output logic [MSG_DW-1:0]      payload
);
    logic pending;

    // Request, payload and pending-flag sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req     <= 1'b0;
            payload <= '0;
            pending <= 1'b0;
        end else if (req) begin
            if (accept) begin
                if (pending || fire) begin
                    payload <= pack_limit(value, scale);
                    pending <= 1'b0;
                end else begin
                    req <= 1'b0;
                end
            end else if (fire) begin
                pending <= 1'b1;
            end
        end else if (fire) begin
            req     <= 1'b1;
            payload <= pack_limit(value, scale);
        end
    end
endmodule

// File: rtl/spl_rx_copy.sv
// Receive-side copy of the limit fields into a device-capabilities image.
// HARDWIRE=1 forces both fields to zero and ignores incoming payloads.
module spl_rx_copy
    import spl_pkg::*;
#(
    parameter bit HARDWIRE = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic [MSG_DW-1:0]      rx_payload,
    output logic [LIMIT_VAL_W-1:0] value,
    output logic [LIMIT_SCL_W-1:0] scale
);
    logic [LIMIT_VAL_W-1:0] value_q;
    logic [LIMIT_SCL_W-1:0] scale_q;

    // Capture the two fields of each received payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            scale_q <= '0;
        end else if (rx_valid) begin
            value_q <= rx_payload[LIMIT_VAL_W-1:0];
            scale_q <= rx_payload[SCALE_LSB +: LIMIT_SCL_W];
        end
    end

    generate
        if (HARDWIRE) begin : g_tied
            // Fields read as zero regardless of traffic.
            assign value = '0;
            assign scale = '0;
        end else begin : g_copy
            // Fields follow the last received payload.
            assign value = value_q;
            assign scale = scale_q;
        end
    endgenerate
endmodule

// File: rtl/spl_msg_gen.sv
// Top of the slot power limit message generator for a downstream port,
// with the receive-side copy used by the port on the far side of the link.
module spl_msg_gen
    import spl_pkg::*;
#(
    parameter bit RX_HARDWIRE = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LIMIT_VAL_W-1:0] slot_value,
    input  logic [LIMIT_SCL_W-1:0] slot_scale,
    input  logic                   slot_cfg_wr,
    input  logic                   slot_init,
    input  logic                   dl_up,
    output logic                   msg_req,
    output logic [MSG_DW-1:0]      msg_payload,
    input  logic                   msg_accept,
    input  logic                   rx_msg_valid,
    input  logic [MSG_DW-1:0]      rx_msg_payload,
    output logic [LIMIT_VAL_W-1:0] dev_limit_value,
    output logic [LIMIT_SCL_W-1:0] dev_limit_scale
);
    logic fire;

    spl_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (slot_cfg_wr),
        .dl_up     (dl_up),
        .slot_init (slot_init),
        .fire      (fire)
    );

    spl_tx_ctrl u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .value   (slot_value),
        .scale   (slot_scale),
        .accept  (msg_accept),
        .req     (msg_req),
        .payload (msg_payload)
    );

    spl_rx_copy #(.HARDWIRE(RX_HARDWIRE)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_msg_valid),
        .rx_payload (rx_msg_payload),
        .value      (dev_limit_value),
        .scale      (dev_limit_scale)
    );
endmodule

// File: rtl/spl_msg_gen_chk.sv
// Protocol checks on the ports of spl_msg_gen, attached with bind.
module spl_msg_gen_chk #(
    parameter bit RX_HARDWIRE = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        slot_cfg_wr,
    input logic        slot_init,
    input logic        dl_up,
    input logic        msg_req,
    input logic [31:0] msg_payload,
    input logic        msg_accept,
    input logic        rx_msg_valid,
    input logic [31:0] rx_msg_payload,
    input logic [7:0]  dev_limit_value,
    input logic [1:0]  dev_limit_scale
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (msg_payload[31:10] == '0));

    p_cfg_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_req && slot_cfg_wr && dl_up) |=> msg_req);

    p_link_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_req && !dl_up) |=> !msg_req);

    p_no_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_req && !slot_init && !slot_cfg_wr) |=> !msg_req);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_accept) |=> (msg_req && $stable(msg_payload)));

    p_rx_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!RX_HARDWIRE && rx_msg_valid) |=>
            (dev_limit_value == $past(rx_msg_payload[7:0]) &&
             dev_limit_scale == $past(rx_msg_payload[9:8])));
endmodule

bind spl_msg_gen spl_msg_gen_chk #(.RX_HARDWIRE(RX_HARDWIRE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_cfg_wr    (slot_cfg_wr),
    .slot_init      (slot_init),
    .dl_up          (dl_up),
    .msg_req        (msg_req),
    .msg_payload    (msg_payload),
    .msg_accept     (msg_accept),
    .rx_msg_valid   (rx_msg_valid),
    .rx_msg_payload (rx_msg_payload),
    .dev_limit_value(dev_limit_value),
    .dev_limit_scale(dev_limit_scale)
);

// File: tb/spl_msg_gen_bench.sv
module spl_msg_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  slot_value = '0;
    logic [1:0]  slot_scale = '0;
    logic        slot_cfg_wr = 1'b0;
    logic        slot_init = 1'b0;
    logic        dl_up = 1'b0;
    logic        msg_accept = 1'b0;
    logic        rx_msg_valid = 1'b0;
    logic [31:0] rx_msg_payload = '0;
    logic        msg_req;
    logic [31:0] msg_payload;
    logic [7:0]  dev_limit_value;
    logic [1:0]  dev_limit_scale;
    logic        hw_req;
    logic [31:0] hw_payload;
    logic [7:0]  hw_value;
    logic [1:0]  hw_scale;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spl_msg_gen u_spl_msg_gen (
        .clk(clk), .rst_n(rst_n), .slot_value(slot_value), .slot_scale(slot_scale),
        .slot_cfg_wr(slot_cfg_wr), .slot_init(slot_init), .dl_up(dl_up),
        .msg_req(msg_req), .msg_payload(msg_payload), .msg_accept(msg_accept),
        .rx_msg_valid(rx_msg_valid), .rx_msg_payload(rx_msg_payload),
        .dev_limit_value(dev_limit_value), .dev_limit_scale(dev_limit_scale)
    );

    spl_msg_gen #(.RX_HARDWIRE(1'b1)) u_spl_msg_gen_hw (
        .clk(clk), .rst_n(rst_n), .slot_value(slot_value), .slot_scale(slot_scale),
        .slot_cfg_wr(slot_cfg_wr), .slot_init(slot_init), .dl_up(dl_up),
        .msg_req(hw_req), .msg_payload(hw_payload), .msg_accept(msg_accept),
        .rx_msg_valid(rx_msg_valid), .rx_msg_payload(rx_msg_payload),
        .dev_limit_value(hw_value), .dev_limit_scale(hw_scale)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_cfg(input logic [7:0] v, input logic [1:0] s);
        slot_value = v; slot_scale = s; slot_cfg_wr = 1'b1;
        step();
        slot_cfg_wr = 1'b0;
    endtask

    task automatic give_accept();
        msg_accept = 1'b1;
        step();
        msg_accept = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk("R1 msg_req after reset", {31'b0, msg_req}, 32'd0);
        chk("R1 dev value after reset", {24'b0, dev_limit_value}, 32'd0);
        chk("R1 dev scale after reset", {30'b0, dev_limit_scale}, 32'd0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_cfg_link_down();
        slot_init = 1'b1; dl_up = 1'b0;
        pulse_cfg(8'h5A, 2'd1);
        chk("R4 write with link down", {31'b0, msg_req}, 32'd0);
        step();
        chk("R4 still idle", {31'b0, msg_req}, 32'd0);
    endtask

    task automatic t_linkup_uninit();
        slot_init = 1'b0; dl_up = 1'b1;
        step();
        chk("R6 link up uninitialized", {31'b0, msg_req}, 32'd0);
        step();
        chk("R6 still idle", {31'b0, msg_req}, 32'd0);
        dl_up = 1'b0;
        step();
    endtask

    task automatic t_linkup_init();
        slot_init = 1'b1; slot_value = 8'hC3; slot_scale = 2'd2; dl_up = 1'b1;
        step();
        chk("R5 link up edge raises request", {31'b0, msg_req}, 32'd1);
        chk("R2 payload layout", msg_payload, 32'h0000_02C3);
        slot_value = 8'h99; slot_scale = 2'd3;
        repeat (3) step();
        chk("R7 request held", {31'b0, msg_req}, 32'd1);
        chk("R7 payload frozen", msg_payload, 32'h0000_02C3);
        give_accept();
        chk("R7 request drops after accept", {31'b0, msg_req}, 32'd0);
        repeat (4) step();
        chk("R5 no resend while link stays up", {31'b0, msg_req}, 32'd0);
    endtask

    task automatic t_cfg_link_up();
        pulse_cfg(8'h11, 2'd3);
        chk("R3 write with link up", {31'b0, msg_req}, 32'd1);
        chk("R3 payload from written fields", msg_payload, 32'h0000_0311);
        give_accept();
        chk("R3 request done", {31'b0, msg_req}, 32'd0);
    endtask

    task automatic t_pending();
        pulse_cfg(8'h20, 2'd0);
        chk("R8 first request", msg_payload, 32'h0000_0020);
        pulse_cfg(8'h21, 2'd0);
        pulse_cfg(8'h22, 2'd1);
        chk("R8 first still waiting", {31'b0, msg_req}, 32'd1);
        chk("R8 first payload kept", msg_payload, 32'h0000_0020);
        give_accept();
        chk("R8 follow-up raised", {31'b0, msg_req}, 32'd1);
        chk("R8 follow-up has latest fields", msg_payload, 32'h0000_0122);
        give_accept();
        chk("R8 exactly one follow-up", {31'b0, msg_req}, 32'd0);
        step();
        chk("R8 still idle", {31'b0, msg_req}, 32'd0);
    endtask

    task automatic t_rx();
        rx_msg_valid = 1'b1; rx_msg_payload = 32'hFFFF_FE7E;
        step();
        rx_msg_valid = 1'b0; rx_msg_payload = 32'h0000_0155;
        chk("R9 value copied", {24'b0, dev_limit_value}, 32'h7E);
        chk("R9 scale copied", {30'b0, dev_limit_scale}, 32'd2);
        chk("R10 hardwired value", {24'b0, hw_value}, 32'd0);
        chk("R10 hardwired scale", {30'b0, hw_scale}, 32'd0);
        step();
        chk("R9 hold without valid", {22'b0, dev_limit_scale, dev_limit_value}, 32'h27E);
        rx_msg_valid = 1'b1; rx_msg_payload = 32'h0000_0155;
        step();
        rx_msg_valid = 1'b0;
        chk("R9 second copy", {22'b0, dev_limit_scale, dev_limit_value}, 32'h155);
        chk("R10 hardwired after second", {22'b0, hw_scale, hw_value}, 32'd0);
    endtask

    initial begin
        step();
        t_reset();
        t_cfg_link_down();
        t_linkup_uninit();
        t_linkup_init();
        t_cfg_link_up();
        t_pending();
        t_rx();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule